// File: doc/BRIEF.md
# Descriptor-Chained DMA Transfer Sequencer

This block runs a single DMA channel over one word-wide valid/ready memory port. In descriptor mode it reads a four-word descriptor from memory, made up of a next pointer, a source address, a target address and a command word. It then copies data in bursts. Each burst reads up to one burst of bytes from the source into a local 32-byte buffer, and only then writes the buffer out to the target. The command word gives the byte count, the beat width, the burst size, the address increment flags and peripheral flow control. When a descriptor finishes, the channel either follows the next pointer or halts.

A host starts the channel with a one-cycle `start_i` pulse. With `nodesc_i` low, the channel fetches the descriptor at `desc_ptr_i`. With `nodesc_i` high, it takes the source, target and command directly from the `src_i`, `dst_i` and `cmd_i` inputs. In flow-controlled mode a peripheral paces the transfer through `req_i`. If the request drops at a burst boundary, the channel raises end-of-request and then pauses, stops or jumps to the next descriptor. Sticky status outputs report start, end, end-of-request, stop, unsupported-mode and error events. Every sticky flag clears on the next start.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, and whenever the channel is idle, `run_o` is low and `mem_valid_o` is low. All status flags reset low and clear on every accepted `start_i`.
- R2: The descriptor fetch address is the pointer with bits 3:0 cleared. When pointer bit 1 is set and `cmp_st_i` is high, 32 is added to it. The four words at that address are read in order as next pointer, source, target and command.
- R3: The command fields are as follows. Bits 12:0 are the byte length. Width code w in bits 15:14 gives beats of 1<<(w-1) bytes. Size code s in bits 17:16 gives bursts of 4<<s bytes. Bit 31 makes the source address advance and bit 30 makes the target address advance, each by the width after every beat.
- R4: Each burst moves min(remaining, burst) bytes. All of its source reads finish before its first target write. A sub-word beat uses byte enables and data lanes selected by address bits 1:0.
- R5: After each burst the remaining length on `len_o` drops by the burst size, and it ends at zero. `src_o` and `dst_o` end at their start values plus the bytes moved, for each address whose increment bit is set.
- R6: Command bit 29 enables flow control on the source and bit 28 enables it on the target. An enabled address has bits 1:0 cleared when it is loaded. While either bit is set, a burst starts only while `req_i` is high.
- R7: In flow-controlled mode, if `req_i` is low when a burst ends, `eor_o` is set. The channel then halts with `stop_o` if `eor_stop_en_i` is set. Otherwise it fetches the next descriptor if `eor_jmp_en_i` is set in descriptor mode. Otherwise it pauses, still running, until the request returns.
- R8: When the length reaches zero, `end_o` is set if command bit 21 is set. The channel halts with `stop_o` if it is in no-descriptor mode, next-pointer bit 0 is set, or `eor_stop_en_i` is set. Otherwise it fetches the descriptor named by the next pointer.
- R9: A fetched command with bit 22 set raises `start_o`. A fetched command with any of bits 25, 20 or 19 set raises `unsup_o`, and the transfer still runs.
- R10: A width code of 0 raises `err_o` and halts the channel with `stop_o` before any data beat is issued.
- R11: A memory request keeps its valid, address and direction unchanged until `mem_ready_i` accepts it. Data stays correct under any pattern of ready stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| nodesc_i | input | 1 | Run from the direct inputs instead of fetching a descriptor |
| desc_ptr_i | input | ADDR_W | First descriptor pointer |
| cmp_st_i | input | 1 | Compare status that selects the branch descriptor |
| eor_stop_en_i | input | 1 | Halt on end-of-request |
| eor_jmp_en_i | input | 1 | Fetch the next descriptor on end-of-request |
| src_i | input | ADDR_W | Source address in no-descriptor mode |
| dst_i | input | ADDR_W | Target address in no-descriptor mode |
| cmd_i | input | 32 | Command word in no-descriptor mode |
| req_i | input | 1 | Peripheral request |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request; read data is valid in the same cycle |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| run_o | output | 1 | Channel active |
| src_o | output | ADDR_W | Current source address |
| dst_o | output | ADDR_W | Current target address |
| len_o | output | 13 | Remaining byte length |
| start_o | output | 1 | Start status |
| end_o | output | 1 | End-of-transfer status |
| eor_o | output | 1 | End-of-request status |
| stop_o | output | 1 | Stopped status |
| unsup_o | output | 1 | Unsupported mode fetched |
| err_o | output | 1 | Illegal width code |

## Verification
The burst that brings the length to zero can also be the burst after which the peripheral request is found low. In that case end-of-request and completion are handled on the same edge. The bench provokes this with a four-byte flow-controlled transfer and drops `req_i` in the cycle where the only write beat is on the port. It then expects `eor_o`, `end_o` and `stop_o` all set together, a zero length, and a halted channel. This shows that completion takes priority over pausing.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int LEN_W = 13;
  localparam int CMD_END_IE    = 21;
  localparam int CMD_START_IE  = 22;
  localparam int CMD_FLOW_DST  = 28;
  localparam int CMD_FLOW_SRC  = 29;
  localparam int CMD_INC_DST   = 30;
  localparam int CMD_INC_SRC   = 31;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHK, S_RD, S_WR} seq_st_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic unsup_mode(input logic [31:0] cmd);
    return cmd[25] | cmd[20] | cmd[19];
  endfunction
endpackage

// File: rtl/dma_seq_lane.sv
module dma_seq_lane (
  input  logic [1:0]  addr_lo_i,
  input  logic [2:0]  nbytes_i,
  input  logic [31:0] rdata_i,
  input  logic [31:0] bdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] rbytes_o,
  output logic [31:0] wdata_o
);
  logic [3:0] mask;
  always_comb begin
    case (nbytes_i)
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end
  assign be_o     = mask << addr_lo_i;
  assign rbytes_o = rdata_i >> {addr_lo_i, 3'b000};
  assign wdata_o  = bdata_i << {addr_lo_i, 3'b000};
endmodule

// File: rtl/dma_seq_buf.sv
module dma_seq_buf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [2:0]    nbytes_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < 4; k++)
        if (k < int'(nbytes_i)) mem_q[idx_i + IW'(k)] <= wdata_i[8*k +: 8];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_rd
    assign rdata_o[8*g +: 8] = mem_q[idx_i + IW'(g)];
  end
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              nodesc_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  input  logic              cmp_st_i,
  input  logic              eor_stop_en_i,
  input  logic              eor_jmp_en_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [31:0]       cmd_i,
  input  logic              req_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              start_o,
  output logic              end_o,
  output logic              eor_o,
  output logic              stop_o,
  output logic              unsup_o,
  output logic              err_o
);
  localparam int IW    = $clog2(BUF_BYTES);
  localparam int CNT_W = IW + 1;

  seq_st_e           st_q;
  logic [ADDR_W-1:0] next_q, src_q, dst_q, base_q, cur_addr;
  logic [31:0]       cmd_q;
  logic [1:0]        widx_q;
  logic [CNT_W-1:0]  cnt_q, bsize_q, burst_b, bsize_nx, wb_ext;
  logic              nodesc_q;
  logic              start_q, end_q, eor_q, stop_q, unsup_q, err_q;
  logic [2:0]        wb;
  logic [LEN_W-1:0]  len_w, new_len;
  logic              flow, burst_last, eor_hit, halt_c;
  logic [3:0]        lane_be;
  logic [31:0]       rbytes, bdata, lane_wdata;

  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [ADDR_W-1:0] p, input logic c);
    return {p[ADDR_W-1:4], 4'b0000} + ((p[1] && c) ? ADDR_W'(32) : ADDR_W'(0));
  endfunction

  assign wb         = width_bytes(cmd_q[15:14]);
  assign wb_ext     = CNT_W'(wb);
  assign burst_b    = CNT_W'(4) << cmd_q[17:16];
  assign len_w      = cmd_q[LEN_W-1:0];
  assign bsize_nx   = (len_w < LEN_W'(burst_b)) ? CNT_W'(len_w) : burst_b;
  assign new_len    = len_w - LEN_W'(bsize_q);
  assign flow       = cmd_q[CMD_FLOW_SRC] | cmd_q[CMD_FLOW_DST];
  assign burst_last = (cnt_q + wb_ext) >= bsize_q;
  assign eor_hit    = flow && !req_i;
  assign halt_c     = nodesc_q | next_q[0] | eor_stop_en_i;

  always_comb begin
    case (st_q)
      S_FETCH: cur_addr = base_q + ADDR_W'({widx_q, 2'b00});
      S_RD:    cur_addr = src_q;
      default: cur_addr = dst_q;
    endcase
  end

  dma_seq_lane i_lane (
    .addr_lo_i(cur_addr[1:0]), .nbytes_i(wb), .rdata_i(mem_rdata_i),
    .bdata_i(bdata), .be_o(lane_be), .rbytes_o(rbytes), .wdata_o(lane_wdata)
  );

  dma_seq_buf #(.DEPTH(BUF_BYTES)) i_buf (
    .clk_i(clk_i), .we_i(st_q == S_RD && mem_ready_i), .idx_i(cnt_q[IW-1:0]),
    .nbytes_i(wb), .wdata_i(rbytes), .rdata_o(bdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; next_q <= '0; src_q <= '0; dst_q <= '0; base_q <= '0;
      cmd_q <= '0; widx_q <= '0; cnt_q <= '0; bsize_q <= '0; nodesc_q <= 1'b0;
      {start_q, end_q, eor_q, stop_q, unsup_q, err_q} <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          {start_q, end_q, eor_q, stop_q, unsup_q, err_q} <= '0;
          nodesc_q <= nodesc_i;
          if (nodesc_i) begin
            src_q <= cmd_i[CMD_FLOW_SRC] ? {src_i[ADDR_W-1:2], 2'b00} : src_i;
            dst_q <= cmd_i[CMD_FLOW_DST] ? {dst_i[ADDR_W-1:2], 2'b00} : dst_i;
            cmd_q <= cmd_i;
            if (cmd_i[15:14] == 2'd0) begin
              err_q <= 1'b1; stop_q <= 1'b1;
            end else st_q <= S_CHK;
          end else begin
            base_q <= fetch_addr(desc_ptr_i, cmp_st_i);
            widx_q <= '0;
            st_q   <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ready_i) begin
          widx_q <= widx_q + 2'd1;
          case (widx_q)
            2'd0: next_q <= ADDR_W'(mem_rdata_i);
            2'd1: src_q  <= ADDR_W'(mem_rdata_i);
            2'd2: dst_q  <= ADDR_W'(mem_rdata_i);
            default: begin
              cmd_q <= mem_rdata_i;
              if (mem_rdata_i[CMD_FLOW_SRC]) src_q[1:0] <= 2'b00;
              if (mem_rdata_i[CMD_FLOW_DST]) dst_q[1:0] <= 2'b00;
              if (unsup_mode(mem_rdata_i)) unsup_q <= 1'b1;
              if (mem_rdata_i[CMD_START_IE]) start_q <= 1'b1;
              if (mem_rdata_i[15:14] == 2'd0) begin
                err_q <= 1'b1; stop_q <= 1'b1; st_q <= S_IDLE;
              end else st_q <= S_CHK;
            end
          endcase
        end
        S_CHK: if (!eor_hit) begin
          if (len_w == '0) begin
            if (cmd_q[CMD_END_IE]) end_q <= 1'b1;
            if (halt_c) begin
              stop_q <= 1'b1; st_q <= S_IDLE;
            end else begin
              base_q <= fetch_addr(next_q, cmp_st_i); widx_q <= '0; st_q <= S_FETCH;
            end
          end else begin
            bsize_q <= bsize_nx; cnt_q <= '0; st_q <= S_RD;
          end
        end
        S_RD: if (mem_ready_i) begin
          if (cmd_q[CMD_INC_SRC]) src_q <= src_q + ADDR_W'(wb);
          if (burst_last) begin
            cnt_q <= '0; st_q <= S_WR;
          end else cnt_q <= cnt_q + wb_ext;
        end
        S_WR: if (mem_ready_i) begin
          if (cmd_q[CMD_INC_DST]) dst_q <= dst_q + ADDR_W'(wb);
          cnt_q <= cnt_q + wb_ext;
          if (burst_last) begin
            cmd_q[LEN_W-1:0] <= new_len;
            if (eor_hit) eor_q <= 1'b1;
            if (new_len == '0) begin
              if (cmd_q[CMD_END_IE]) end_q <= 1'b1;
              if (halt_c) begin
                stop_q <= 1'b1; st_q <= S_IDLE;
              end else begin
                base_q <= fetch_addr(next_q, cmp_st_i); widx_q <= '0; st_q <= S_FETCH;
              end
            end else if (eor_hit && eor_stop_en_i) begin
              stop_q <= 1'b1; st_q <= S_IDLE;
            end else if (eor_hit && eor_jmp_en_i && !nodesc_q) begin
              base_q <= fetch_addr(next_q, cmp_st_i); widx_q <= '0; st_q <= S_FETCH;
            end else st_q <= S_CHK;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (st_q == S_FETCH) || (st_q == S_RD) || (st_q == S_WR);
  assign mem_we_o    = (st_q == S_WR);
  assign mem_addr_o  = {cur_addr[ADDR_W-1:2], 2'b00};
  assign mem_be_o    = (st_q == S_FETCH) ? 4'hf : lane_be;
  assign mem_wdata_o = lane_wdata;
  assign run_o       = (st_q != S_IDLE);
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign len_o       = len_w;
  assign start_o     = start_q;
  assign end_o       = end_q;
  assign eor_o       = eor_q;
  assign stop_o      = stop_q;
  assign unsup_o     = unsup_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dma_desc_seq_chk.sv
module dma_desc_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              run_o,
  input logic              stop_o,
  input logic              err_o
);
  // R1
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !mem_valid_o);
  // R4
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                     $countones(mem_be_o) == 4));
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !run_o);
  // R10
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!run_o && stop_o));
endmodule

bind dma_desc_seq dma_desc_seq_chk #(.ADDR_W(ADDR_W)) i_dma_desc_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
  .run_o(run_o), .stop_o(stop_o), .err_o(err_o)
);

// File: tb/test_dma_desc_seq.sv
`timescale 1ns/1ps
module test_dma_desc_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, nodesc, cmp_st, eor_stop, eor_jmp, req;
  logic [31:0] desc_ptr, src_in, dst_in, cmd_in;
  logic mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic run, st_f, end_f, eor_f, stop_f, unsup_f, err_f;
  logic [31:0] src_q, dst_q;
  logic [12:0] len_q;

  dma_desc_seq i_dma_desc_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nodesc_i(nodesc), .desc_ptr_i(desc_ptr),
    .cmp_st_i(cmp_st), .eor_stop_en_i(eor_stop), .eor_jmp_en_i(eor_jmp), .src_i(src_in),
    .dst_i(dst_in), .cmd_i(cmd_in), .req_i(req), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .run_o(run), .src_o(src_q), .dst_o(dst_q), .len_o(len_q),
    .start_o(st_f), .end_o(end_f), .eor_o(eor_f), .stop_o(stop_f), .unsup_o(unsup_f), .err_o(err_f)
  );

  // behavioural memory, 1 KiB
  logic [31:0] mem [256];
  logic [7:0]  lfsr = 8'h5a;
  logic        stall_en = 1'b0;
  assign mem_ready = stall_en ? lfsr[0] : 1'b1;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_valid && mem_ready && mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
  end

  int n_chk = 0, n_fail = 0;
  logic [7:0] eb [1024];
  logic [7:0] tmp [32];

  localparam logic [31:0] INC_S = 32'h8000_0000, INC_D = 32'h4000_0000;
  localparam logic [31:0] FLOW_S = 32'h2000_0000, END_IE = 32'h0020_0000;
  localparam logic [31:0] START_IE = 32'h0040_0000, UNSUP = 32'h0200_0000;
  localparam logic [31:0] W1 = 32'h0000_4000, W2 = 32'h0000_8000, W4 = 32'h0000_c000;

  // {src, dst, cmd}: cmd = inc flags | size code<<16 | width code<<14 | length
  localparam logic [95:0] VEC [6] = '{
    {32'h100, 32'h200, INC_S | INC_D | END_IE | 32'h0001_0000 | W4 | 32'd20},
    {32'h101, 32'h203, INC_S | INC_D | END_IE | 32'h0000_0000 | W1 | 32'd7},
    {32'h102, 32'h212, INC_S | INC_D | END_IE | 32'h0003_0000 | W2 | 32'd40},
    {32'h100, 32'h2f0, INC_S | END_IE | 32'h0002_0000 | W4 | 32'd12},
    {32'h110, 32'h220, INC_D | END_IE | 32'h0000_0000 | W4 | 32'd8},
    {32'h100, 32'h2c0, INC_S | INC_D | END_IE | 32'h0001_0000 | W4 | 32'd0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_desc(input int a, input logic [31:0] nx, s, d, c);
    mem[a/4] = nx; mem[a/4 + 1] = s; mem[a/4 + 2] = d; mem[a/4 + 3] = c;
  endtask

  task automatic go(input logic nd, input logic [31:0] p, s, d, c);
    @(negedge clk);
    nodesc = nd; desc_ptr = p; src_in = s; dst_in = d; cmd_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_halt();
    int t = 0;
    while (run && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) begin n_chk++; n_fail++; $display("FAIL watchdog run_o stuck"); end
  endtask

  task automatic drop_req_on_write();
    int t = 0;
    while (!mem_we && t < 2000) begin @(negedge clk); t++; end
    req = 1'b0;
  endtask

  task automatic snap();
    for (int i = 0; i < 1024; i++) eb[i] = mem[i/4][8*(i%4) +: 8];
  endtask

  // bench model of R3/R4/R5 data movement on eb
  task automatic model(input logic [31:0] s0, d0, c, output logic [31:0] s, d);
    int rem, w, bur, b;
    s = s0; d = d0; rem = int'(c[12:0]);
    w = 1 << (c[15:14] - 1); bur = 4 << c[17:16];
    while (rem > 0) begin
      b = (rem < bur) ? rem : bur;
      for (int n = 0; n < b; n += w) begin
        for (int k = 0; k < w; k++) tmp[n+k] = eb[(s + k) % 1024];
        if (c[31]) s = s + w;
      end
      for (int n = 0; n < b; n += w) begin
        for (int k = 0; k < w; k++) eb[(d + k) % 1024] = tmp[n+k];
        if (c[30]) d = d + w;
      end
      rem -= b;
    end
  endtask

  function automatic int mem_mismatch();
    int m = 0;
    for (int i = 0; i < 1024; i++) if (mem[i/4][8*(i%4) +: 8] !== eb[i]) m++;
    return m;
  endfunction

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog global timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] es, ed, w_before;
    rst_n = 1'b0; start = 0; nodesc = 0; cmp_st = 0; eor_stop = 0; eor_jmp = 0; req = 0;
    desc_ptr = 0; src_in = 0; dst_in = 0; cmd_in = 0;
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'ha5, 8'(i + 1), ~8'(i), 8'(i * 3)};
    repeat (3) @(negedge clk);
    chk("R1 reset run", {31'd0, run}, 0);
    chk("R1 reset valid", {31'd0, mem_valid}, 0);
    chk("R1 reset flags", {26'd0, st_f, end_f, eor_f, stop_f, unsup_f, err_f}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, run, mem_valid}, 0);

    // vector table, direct mode, ready stalls on
    stall_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      snap();
      model(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], es, ed);
      go(1'b1, 0, VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
      wait_halt();
      chk($sformatf("R4 R11 data vec%0d", v), mem_mismatch(), 0);
      chk($sformatf("R3 R5 src vec%0d", v), src_q, es);
      chk($sformatf("R3 R5 dst vec%0d", v), dst_q, ed);
      chk($sformatf("R5 len vec%0d", v), {19'd0, len_q}, 0);
      chk($sformatf("R8 end stop vec%0d", v), {30'd0, end_f, stop_f}, 2'b11);
    end
    stall_en = 1'b0;

    // R6: source flow control masks low bits and waits for request
    req = 1'b0; eor_stop = 0; eor_jmp = 0;
    go(1'b1, 0, 32'h106, 32'h230, FLOW_S | INC_D | W4 | 32'd16);
    chk("R6 src low bits cleared", src_q, 32'h104);
    repeat (20) @(negedge clk);
    chk("R6 waits for request len", {19'd0, len_q}, 16);
    chk("R6 waits running no bus", {30'd0, run, mem_valid}, 2'b10);
    // R7: request drops after first burst -> eor, pause
    req = 1'b1;
    drop_req_on_write();
    repeat (4) @(negedge clk);
    chk("R7 eor pause flags", {29'd0, eor_f, stop_f, run}, 3'b101);
    chk("R7 eor pause len", {19'd0, len_q}, 12);
    req = 1'b1;
    wait_halt();
    chk("R7 resume to completion", dst_q, 32'h240);
    chk("R7 resume len", {19'd0, len_q}, 0);

    // R7: eor with stop enabled
    eor_stop = 1'b1; req = 1'b1;
    go(1'b1, 0, 32'h104, 32'h230, FLOW_S | INC_D | W4 | 32'd16);
    drop_req_on_write();
    repeat (4) @(negedge clk);
    chk("R7 eor stop", {29'd0, eor_f, stop_f, run}, 3'b110);
    chk("R7 eor stop len", {19'd0, len_q}, 12);
    eor_stop = 1'b0;

    // R7: eor with jump to next descriptor
    set_desc(32'h40, 32'h60, 32'h108, 32'h240, FLOW_S | INC_S | INC_D | W4 | 32'd16);
    set_desc(32'h60, 32'h1, 32'h120, 32'h250, INC_S | INC_D | 32'h0001_0000 | W4 | 32'd8);
    eor_jmp = 1'b1; req = 1'b1;
    go(1'b0, 32'h40, 0, 0, 0);
    drop_req_on_write();
    wait_halt();
    chk("R7 jump dst", dst_q, 32'h258);
    chk("R7 jump data", mem[32'h250/4], mem[32'h120/4]);
    chk("R7 jump flags", {30'd0, eor_f, stop_f}, 2'b11);
    eor_jmp = 1'b0;

    // EOR coinciding with completion: completion wins
    req = 1'b1;
    go(1'b1, 0, 32'h10c, 32'h260, FLOW_S | INC_S | INC_D | END_IE | W4 | 32'd4);
    drop_req_on_write();
    wait_halt();
    chk("R7 R8 eor and end same edge", {28'd0, eor_f, end_f, stop_f, run}, 4'b1110);
    chk("R8 len zero after coincidence", {19'd0, len_q}, 0);

    // R8/R9: chain of two descriptors
    set_desc(32'h80, 32'ha0, 32'h100, 32'h270, INC_S | INC_D | START_IE | W4 | 32'd4);
    set_desc(32'ha0, 32'h1, 32'h104, 32'h274, INC_S | INC_D | END_IE | W4 | 32'd4);
    stall_en = 1'b1;
    go(1'b0, 32'h80, 0, 0, 0);
    wait_halt();
    stall_en = 1'b0;
    chk("R8 chain first word", mem[32'h270/4], mem[32'h100/4]);
    chk("R8 chain second word", mem[32'h274/4], mem[32'h104/4]);
    chk("R8 chain dst", dst_q, 32'h278);
    chk("R9 start flag", {29'd0, st_f, end_f, stop_f}, 3'b111);

    // R2: branch offset and low-bit clear, R9 unsupported
    set_desc(32'hc0, 32'h1, 32'h100, 32'h2a0, INC_S | INC_D | UNSUP | W4 | 32'd4);
    set_desc(32'he0, 32'h1, 32'h100, 32'h2b0, INC_S | INC_D | W4 | 32'd4);
    cmp_st = 1'b0;
    go(1'b0, 32'hca, 0, 0, 0);
    wait_halt();
    chk("R2 no branch when compare low", dst_q, 32'h2a4);
    chk("R9 unsupported flag", {31'd0, unsup_f}, 1);
    cmp_st = 1'b1;
    go(1'b0, 32'hc2, 0, 0, 0);
    wait_halt();
    chk("R2 branch adds 32", dst_q, 32'h2b4);
    chk("R9 unsupported clear on normal cmd", {31'd0, unsup_f}, 0);
    cmp_st = 1'b0;

    // R10: width code 0
    w_before = mem[32'h2e0/4];
    go(1'b1, 0, 32'h100, 32'h2e0, INC_S | INC_D | 32'd8);
    chk("R10 err halts", {29'd0, err_f, stop_f, run}, 3'b110);
    repeat (5) @(negedge clk);
    chk("R10 no data written", mem[32'h2e0/4], w_before);
    chk("R1 flags cleared on start", {31'd0, eor_f}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule